// File: doc/BRIEF.md
# A/D Converter Control and Status Register

This block is the single 8-bit control/status register of a multi-channel successive-approximation A/D converter. It sits on a simple CPU register bus with a select, a read strobe, a write strobe and 8-bit write and read data. It holds the converter's control fields: channel select, conversion clock select, scan-mode enable, start and interrupt enable. It also holds a sticky end-of-conversion flag, and it raises the converter's interrupt request from that flag.

The analog core is not part of the block. Two pulse inputs report a finished single conversion and a finished scan group. The flag sets on whichever of the two pulses matches the current mode. Software clears the flag in two steps: it first reads the register while the flag is 1, then writes 0 to the flag bit. A transfer controller that services the interrupt clears the flag by reading the conversion result. Standby and module-stop inputs force the whole register back to its reset value.

Top module: `adc_csr`

## Requirements
- R1: After reset the register reads 0x00. The bit layout is: bit 7 end flag, bit 6 interrupt enable, bit 5 start, bit 4 scan mode, bit 3 clock select, bits 2:0 channel. `rd_data` is 0x00 whenever `sel` is low.
- R2: While `standby` or `mod_stop` is high, the next clock edge clears all eight bits and any pending read qualification.
- R3: A bus write never sets bit 7, even when the written bit 7 is 1.
- R4: A write of 0 to bit 7 that follows no qualifying read leaves a set flag at 1.
- R5: A bus read taken while the flag is 1 qualifies the flag for clearing. The next write then clears the flag if its bit 7 is 0. Every write ends the qualification, whatever its bit 7 holds.
- R6: With bit 4 at 0, a `conv_done` pulse sets the flag at the next edge, and `scan_done` has no effect.
- R7: With bit 4 at 1, a `scan_done` pulse sets the flag at the next edge, and `conv_done` has no effect.
- R8: When a set condition and a clear condition occur in the same cycle, the flag ends at 1.
- R9: `dma_rd` while `irq` is high clears the flag at the next edge. `dma_rd` while `irq` is low has no effect.
- R10: `irq` is high exactly when both the flag and bit 6 are 1.
- R11: A bus write loads bits 6:0 from `wr_data[6:0]` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Standby mode active; clears the register |
| mod_stop | input | 1 | Module stop active; clears the register |
| sel | input | 1 | Register select |
| rd_en | input | 1 | CPU read strobe |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register contents when selected, else zero |
| conv_done | input | 1 | Single conversion complete pulse |
| scan_done | input | 1 | Scan group complete pulse |
| dma_rd | input | 1 | Transfer controller reads the result register |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
The set path and the clear path can act on the flag in the same cycle. A completion pulse for the active mode can coincide with a qualified zero write or with a transfer-controller read. The bench provokes this directly: it qualifies the flag with a read, then issues the clearing write together with `scan_done` in scan mode. Random traffic also overlaps pulses with writes and DMA reads many times. In every such cycle the bench model requires the flag to stay at 1 after the edge, and the checker asserts that a set condition without standby always leaves the flag set.

// File: rtl/adc_csr.sv
module adc_csr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby,
  input  logic       mod_stop,
  input  logic       sel,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       conv_done,
  input  logic       scan_done,
  input  logic       dma_rd,
  output logic       irq
);

  logic       end_flag;
  logic [6:0] ctl;
  logic       rd_armed;

  wire bus_wr   = sel & wr_en;
  wire bus_rd   = sel & rd_en;
  wire scan_on  = ctl[4];
  wire done_hit = scan_on ? scan_done : conv_done;
  wire sw_clear = bus_wr & rd_armed & ~wr_data[7];
  wire dma_clr  = dma_rd & irq;
  wire halt     = standby | mod_stop;

  assign irq     = end_flag & ctl[6];
  assign rd_data = sel ? {end_flag, ctl} : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_flag <= 1'b0;
      ctl      <= '0;
      rd_armed <= 1'b0;
    end else if (halt) begin
      end_flag <= 1'b0;
      ctl      <= '0;
      rd_armed <= 1'b0;
    end else begin
      if (bus_wr)
        ctl <= wr_data[6:0];

      if (bus_wr)
        rd_armed <= 1'b0;
      else if (bus_rd && end_flag)
        rd_armed <= 1'b1;

      if (done_hit)
        end_flag <= 1'b1;
      else if (sw_clear || dma_clr)
        end_flag <= 1'b0;
    end
  end

endmodule

module adc_csr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       standby,
  input logic       mod_stop,
  input logic       sel,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       conv_done,
  input logic       scan_done,
  input logic       dma_rd,
  input logic       irq,
  input logic       end_flag,
  input logic [6:0] ctl,
  input logic       rd_armed
);

  a_r2_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (standby || mod_stop) |=> (end_flag == 1'b0 && ctl == 7'd0 && !rd_armed));

  a_r3_flag_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> $past(ctl[4] ? scan_done : conv_done));

  a_r4_flag_fall_source: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(end_flag) |-> $past((sel && wr_en && rd_armed && !wr_data[7]) ||
                              (dma_rd && irq) || standby || mod_stop));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && !mod_stop && (ctl[4] ? scan_done : conv_done)) |=> end_flag);

  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(conv_done || scan_done || (sel && wr_en && wr_data[6])));

  a_r11_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && !standby && !mod_stop) |=> ctl == $past(wr_data[6:0]));

  a_r1_deselected_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> rd_data == 8'h00);

endmodule

bind adc_csr adc_csr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .mod_stop(mod_stop),
  .sel(sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .conv_done(conv_done), .scan_done(scan_done), .dma_rd(dma_rd), .irq(irq),
  .end_flag(end_flag), .ctl(ctl), .rd_armed(rd_armed)
);

// File: tb/test_adc_csr.sv
`timescale 1ns/1ps
module test_adc_csr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby = 0, mod_stop = 0, sel = 0, rd_en = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic conv_done = 0, scan_done = 0, dma_rd = 0;
  logic [7:0] rd_data;
  logic irq;

  int n_run = 0, n_fail = 0;
  logic [8:0] m = '0;

  always #4 clk = ~clk;

  adc_csr i_adc_csr (
    .clk(clk), .rst_n(rst_n), .standby(standby), .mod_stop(mod_stop),
    .sel(sel), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .conv_done(conv_done), .scan_done(scan_done), .dma_rd(dma_rd), .irq(irq)
  );

  // model state: bit 8 = pending read qualification, bits 7:0 = register
  function automatic logic [8:0] nxt(logic [8:0] s, logic sb, logic ms, logic sl,
      logic rd, logic wr, logic [7:0] wd, logic cd, logic sd, logic dr);
    logic [8:0] n;
    logic set_c, clr_c;
    if (sb || ms) return 9'd0;
    n = s;
    set_c = s[4] ? sd : cd;
    clr_c = (sl && wr && s[8] && !wd[7]) || (dr && s[7] && s[6]);
    if (sl && wr) begin n[6:0] = wd[6:0]; n[8] = 1'b0; end
    else if (sl && rd && s[7]) n[8] = 1'b1;
    if (set_c) n[7] = 1'b1;
    else if (clr_c) n[7] = 1'b0;
    return n;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic cyc(string tag, logic sb, logic ms, logic sl, logic rd, logic wr,
      logic [7:0] wd, logic cd, logic sd, logic dr);
    @(negedge clk);
    standby = sb; mod_stop = ms; sel = sl; rd_en = rd; wr_en = wr;
    wr_data = wd; conv_done = cd; scan_done = sd; dma_rd = dr;
    m = nxt(m, sb, ms, sl, rd, wr, wd, cd, sd, dr);
    @(posedge clk);
    #1;
    standby = 0; mod_stop = 0; rd_en = 0; wr_en = 0;
    conv_done = 0; scan_done = 0; dma_rd = 0; sel = 1;
    #1;
    chk({tag, " reg"}, rd_data, m[7:0]);
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, m[7] & m[6]});
  endtask

  task automatic wr(string tag, logic [7:0] d, logic cd = 0, logic sd = 0);
    cyc(tag, 0, 0, 1, 0, 1, d, cd, sd, 0);
  endtask
  task automatic rd(string tag);
    cyc(tag, 0, 0, 1, 1, 0, 8'h00, 0, 0, 0);
  endtask

  initial begin
    #(8ns * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset deselected", rd_data, 8'h00);
    sel = 1; #1;
    chk("R1 reset value", rd_data, 8'h00);
    @(negedge clk); rst_n = 1;

    wr("R11 load ctl", 8'h7F);
    sel = 0; #1; chk("R1 deselected reads zero", rd_data, 8'h00);
    cyc("R2 standby", 1, 0, 1, 0, 0, 8'h00, 0, 0, 0);
    wr("R11 load ctl", 8'h2B);
    cyc("R2 module stop", 0, 1, 1, 0, 0, 8'h00, 0, 0, 0);
    wr("R3 write one to flag", 8'h80);
    wr("R6 single mode", 8'h00);
    wr("R6 scan pulse ignored", 8'h00, 0, 1);
    cyc("R6 conv_done sets", 0, 0, 0, 0, 0, 8'h00, 1, 0, 0);
    wr("R4 zero without read", 8'h00);
    rd("R5 qualifying read");
    wr("R5 write one consumes", 8'h80);
    wr("R5 zero after consume", 8'h00);
    rd("R5 qualifying read");
    wr("R5 qualified clear", 8'h00);
    wr("R7 scan mode", 8'h10);
    cyc("R7 conv ignored", 0, 0, 0, 0, 0, 8'h00, 1, 0, 0);
    cyc("R7 scan_done sets", 0, 0, 0, 0, 0, 8'h00, 0, 1, 0);
    rd("R8 qualifying read");
    wr("R8 set wins over write clear", 8'h10, 0, 1);
    cyc("R9 dma while irq low", 0, 0, 0, 0, 0, 8'h00, 0, 0, 1);
    wr("R10 enable irq", 8'h50);
    cyc("R8 set wins over dma clear", 0, 0, 0, 0, 0, 8'h00, 0, 1, 1);
    cyc("R9 dma clear", 0, 0, 0, 0, 0, 8'h00, 0, 0, 1);
    cyc("R10 irq rises with flag", 0, 0, 0, 0, 0, 8'h00, 0, 1, 0);
    wr("R10 mask irq", 8'h10);
    cyc("R2 standby clears flag", 1, 0, 0, 0, 0, 8'h00, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      cyc("R5 R8 R9 random", ($urandom % 60) == 0, ($urandom % 80) == 0,
          ($urandom % 5) != 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
          8'($urandom), ($urandom % 6) == 0, ($urandom % 6) == 0,
          ($urandom % 6) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule